// File: doc/BRIEF.md
# Memory Low-Power Entry Controller

This block sits beside the command scheduler of a DDR2-class memory controller and decides when the attached device may leave its active state. It counts the clocks since the last transfer or request. When a programmed idle threshold is reached, it drops the clock enable and issues a one-cycle strobe for the selected low-power kind: self-refresh, power-down or deep power-down.

When a new request arrives while the device is parked, the block raises the clock enable again and pulses a wake strobe. It then holds a busy output for an exit wait. The length of that wait depends on the low-power kind that was entered, on whether the waking request is a read, and on the power-down exit speed. The scheduler must not issue the waiting command while busy is high.

Top module: `ddr_lp_entry`

## Requirements
- R1: With the mode field at 0, the block never enters low power: cke stays 1 and no entry strobe is issued.
- R2: When entry happens, the mode field value picks the strobe: 1 pulses cmd_self_refresh, 2 pulses cmd_power_down, 3 pulses cmd_deep_pd. The strobe is high for exactly one cycle, and cke goes low on the same edge.
- R3: The timeout field picks an idle threshold T: 0 gives T=0, 1 gives T=64, 2 gives T=128, and the spare code 3 behaves as 0. Entry happens on the (T+1)-th consecutive clock edge that samples xfer_active=0 and new_req=0.
- R4: While the block is active, xfer_active or new_req high at an edge blocks entry at that edge and restarts the idle count from zero.
- R5: While the block is in low power, new_req at an edge pulses cmd_wake for one cycle and raises cke on that edge. busy is then high for exactly D cycles, where D is the exit wait; after that the block is active again.
- R6: After self-refresh, D is 208 clocks for a read (req_is_read=1) and 16 clocks for a non-read.
- R7: After power-down, D is 2 clocks for a non-read. For a read, D is the fast read wait (default 7) when cfg_slow_exit=0 and the slow read wait (default 7) when cfg_slow_exit=1. cfg_slow_exit is sampled on the waking edge.
- R8: After deep power-down, D is the deep exit wait (default 208) whatever the request type.
- R9: The low-power kind is captured at entry. Changing cfg_mode or cfg_timeout while the device is parked has no effect on that stay or on its exit wait.
- R10: Reset (synchronous, active high) leaves cke=1, busy=0 and all strobes low, in the active state.
- R11: After the exit wait, the idle count starts from zero, so the next entry again needs T+1 idle edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power kind: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_timeout | input | 2 | Idle threshold code: 0 immediate, 1 64 clocks, 2 128 clocks, 3 immediate |
| cfg_slow_exit | input | 1 | Power-down exit speed: 0 fast, 1 slow |
| xfer_active | input | 1 | A transfer is in progress |
| new_req | input | 1 | A new request is presented |
| req_is_read | input | 1 | The presented request is a read |
| cke | output | 1 | Clock enable to the memory device |
| busy | output | 1 | Exit wait in progress; hold the next command |
| cmd_self_refresh | output | 1 | One-cycle self-refresh entry strobe |
| cmd_power_down | output | 1 | One-cycle power-down entry strobe |
| cmd_deep_pd | output | 1 | One-cycle deep power-down entry strobe |
| cmd_wake | output | 1 | One-cycle low-power exit strobe |

## Verification
The hardest situation to reach is a change of configuration while the device is parked, followed by a wake. The outcome is only visible as the length of the busy window, and then only for the captured kind. The stimulus parks the block in self-refresh, changes the mode to off and the timeout to 128, and wakes it with a non-read, so the window must still be 16 cycles. Long 128-clock idle stretches happen too rarely under random traffic, so directed runs measure each threshold code edge by edge. Random phases then mix short bursts, sparse requests and reprogramming against a cycle model.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    typedef enum logic [1:0] {
        LP_NONE         = 2'd0,
        LP_SELF_REFRESH = 2'd1,
        LP_POWER_DOWN   = 2'd2,
        LP_DEEP_PD      = 2'd3
    } lp_kind_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LOW    = 2'd1,
        ST_WAKE   = 2'd2
    } lp_state_e;

    typedef struct packed {
        lp_kind_e kind;
        logic     is_read;
        logic     slow;
    } wake_ctx_t;

    // Idle threshold in clocks for a timeout code; code 3 is spare and acts as 0.
    function automatic int unsigned idle_limit(input logic [1:0] code,
                                               input int unsigned short_t,
                                               input int unsigned long_t);
        case (code)
            2'd1:    return short_t;
            2'd2:    return long_t;
            default: return 0;
        endcase
    endfunction

    // Exit wait for the kind that was parked and the request that wakes it.
    function automatic int unsigned wake_delay(input wake_ctx_t   ctx,
                                               input int unsigned sr_rd,
                                               input int unsigned sr_cmd,
                                               input int unsigned pd_cmd,
                                               input int unsigned pd_rd_fast,
                                               input int unsigned pd_rd_slow,
                                               input int unsigned deep);
        case (ctx.kind)
            LP_SELF_REFRESH: return ctx.is_read ? sr_rd : sr_cmd;
            LP_POWER_DOWN:   return ctx.is_read ? (ctx.slow ? pd_rd_slow : pd_rd_fast) : pd_cmd;
            LP_DEEP_PD:      return deep;
            default:         return pd_cmd;
        endcase
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpe_idle_timer.sv
module lpe_idle_timer
    import lpe_pkg::*;
#(
    parameter int unsigned SHORT_IDLE = 64,
    parameter int unsigned LONG_IDLE  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic [1:0] timeout_sel,
    output logic       reached
);
    localparam int unsigned CW = $clog2(LONG_IDLE + 1);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb limit = CW'(idle_limit(timeout_sel, SHORT_IDLE, LONG_IDLE));

    // Saturating count of consecutive idle edges.
    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q >= limit);

    // R4: any activity restarts the idle count
    a_r4_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R3: the count never wraps back to a short value
    a_r3_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (!clear && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/lpe_wake_timer.sv
module lpe_wake_timer #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          last
);
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == DW'(1));

    // R5: the exit wait starts from the selected length
    a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R5: the exit wait shrinks by one per clock
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q > DW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_lp_entry.sv
module ddr_lp_entry
    import lpe_pkg::*;
#(
    parameter int unsigned SHORT_IDLE   = 64,
    parameter int unsigned LONG_IDLE    = 128,
    parameter int unsigned T_PD_CMD     = 2,
    parameter int unsigned T_PD_RD_FAST = 7,
    parameter int unsigned T_PD_RD_SLOW = 7,
    parameter int unsigned T_SR_CMD     = 16,
    parameter int unsigned T_SR_RD      = 208,
    parameter int unsigned T_DEEP       = 208
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_timeout,
    input  logic       cfg_slow_exit,
    input  logic       xfer_active,
    input  logic       new_req,
    input  logic       req_is_read,
    output logic       cke,
    output logic       busy,
    output logic       cmd_self_refresh,
    output logic       cmd_power_down,
    output logic       cmd_deep_pd,
    output logic       cmd_wake
);
    localparam int unsigned MAX_DLY = max2(max2(max2(T_PD_CMD, T_PD_RD_FAST), max2(T_PD_RD_SLOW, T_SR_CMD)),
                                           max2(T_SR_RD, T_DEEP));
    localparam int unsigned DW = $clog2(MAX_DLY + 1);

    lp_state_e state_q;
    lp_kind_e  kind_q;
    lp_kind_e  mode_k;
    wake_ctx_t ctx;
    logic      activity, in_active, idle_reached, enter_now, wake_now, wake_last;
    logic      cke_q, busy_q;
    logic [3:1] enter_q;
    logic      wake_q;
    logic [DW-1:0] wake_len;

    always_comb begin
        mode_k      = lp_kind_e'(cfg_mode);
        activity    = xfer_active || new_req;
        in_active   = (state_q == ST_ACTIVE);
        enter_now   = in_active && (mode_k != LP_NONE) && !activity && idle_reached;
        wake_now    = (state_q == ST_LOW) && new_req;
        ctx.kind    = kind_q;
        ctx.is_read = req_is_read;
        ctx.slow    = cfg_slow_exit;
        wake_len    = DW'(wake_delay(ctx, T_SR_RD, T_SR_CMD, T_PD_CMD,
                                     T_PD_RD_FAST, T_PD_RD_SLOW, T_DEEP));
    end

    lpe_idle_timer #(
        .SHORT_IDLE (SHORT_IDLE),
        .LONG_IDLE  (LONG_IDLE)
    ) u_idle (
        .clk         (clk),
        .rst         (rst),
        .clear       (activity || !in_active),
        .timeout_sel (cfg_timeout),
        .reached     (idle_reached)
    );

    lpe_wake_timer #(
        .DW (DW)
    ) u_wake (
        .clk      (clk),
        .rst      (rst),
        .load     (wake_now),
        .load_val (wake_len),
        .last     (wake_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            kind_q  <= LP_NONE;
            cke_q   <= 1'b1;
            busy_q  <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            case (state_q)
                ST_ACTIVE: begin
                    if (enter_now) begin
                        state_q <= ST_LOW;
                        kind_q  <= mode_k;
                        cke_q   <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (wake_now) begin
                        state_q <= ST_WAKE;
                        cke_q   <= 1'b1;
                        busy_q  <= 1'b1;
                        wake_q  <= 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (wake_last) begin
                        state_q <= ST_ACTIVE;
                        busy_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_ACTIVE;
            endcase
        end
    end

    // One entry strobe per low-power kind, selected by the mode code.
    for (genvar k = 1; k <= 3; k++) begin : g_enter
        always_ff @(posedge clk) begin
            if (rst)
                enter_q[k] <= 1'b0;
            else
                enter_q[k] <= enter_now && (cfg_mode == 2'(k));
        end
    end

    assign cke              = cke_q;
    assign busy             = busy_q;
    assign cmd_self_refresh = enter_q[1];
    assign cmd_power_down   = enter_q[2];
    assign cmd_deep_pd      = enter_q[3];
    assign cmd_wake         = wake_q;

    // R1: mode 0 keeps the device active
    a_r1_off_stays_active: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && cfg_mode == 2'd0) |=> cke);

    // R2: at most one command strobe per cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_self_refresh, cmd_power_down, cmd_deep_pd, cmd_wake}));

    // R2: cke only falls together with an entry strobe
    a_r2_cke_fall_strobed: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (cmd_self_refresh || cmd_power_down || cmd_deep_pd));

    // R4: activity while active blocks entry
    a_r4_activity_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && (xfer_active || new_req)) |=> cke);

    // R5: cke only rises on a request, with wake and busy
    a_r5_cke_rise_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> ($past(new_req) && busy && cmd_wake));

    // R5: the busy window ends with the device active
    a_r5_busy_end_active: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cke && state_q == ST_ACTIVE));

endmodule

// File: tb/ddr_lp_entry_test.sv
module ddr_lp_entry_test;
    localparam int SHORT_T = 64, LONG_T = 128;
    localparam int D_PD_CMD = 2, D_PD_FAST = 7, D_PD_SLOW = 9;
    localparam int D_SR_CMD = 16, D_SR_RD = 208, D_DEEP = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0, cfg_timeout = 2'd0;
    logic cfg_slow_exit = 1'b0, xfer_active = 1'b0, new_req = 1'b0, req_is_read = 1'b0;
    logic cke, busy, cmd_self_refresh, cmd_power_down, cmd_deep_pd, cmd_wake;

    always #10 clk = ~clk;

    ddr_lp_entry #(
        .T_PD_RD_SLOW (D_PD_SLOW),
        .T_DEEP       (D_DEEP)
    ) uut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
        .cfg_slow_exit(cfg_slow_exit), .xfer_active(xfer_active), .new_req(new_req),
        .req_is_read(req_is_read), .cke(cke), .busy(busy),
        .cmd_self_refresh(cmd_self_refresh), .cmd_power_down(cmd_power_down),
        .cmd_deep_pd(cmd_deep_pd), .cmd_wake(cmd_wake)
    );

    int vectors = 0, miscompares = 0;
    string cur_tag = "R10";

    // Cycle model built from the requirements
    int m_st = 0, m_idle = 0, m_kind = 0, m_cnt = 0;
    bit m_sre = 0, m_pde = 0, m_dpde = 0, m_wake = 0;

    function automatic int lim(input logic [1:0] code);
        return (code == 2'd1) ? SHORT_T : (code == 2'd2) ? LONG_T : 0;
    endfunction

    function automatic int dly(input int kind, input bit rd, input bit slow);
        if (kind == 1) return rd ? D_SR_RD : D_SR_CMD;
        if (kind == 2) return rd ? (slow ? D_PD_SLOW : D_PD_FAST) : D_PD_CMD;
        return D_DEEP;
    endfunction

    task automatic model_edge(input bit xa, input bit nr, input bit rd);
        m_sre = 0; m_pde = 0; m_dpde = 0; m_wake = 0;
        case (m_st)
            0: begin
                if (cfg_mode != 0 && !xa && !nr && m_idle >= lim(cfg_timeout)) begin
                    m_st = 1; m_kind = cfg_mode; m_idle = 0;
                    m_sre = (m_kind == 1); m_pde = (m_kind == 2); m_dpde = (m_kind == 3);
                end else if (xa || nr) m_idle = 0;
                else if (m_idle < 255) m_idle++;
            end
            1: begin
                m_idle = 0;
                if (nr) begin m_st = 2; m_cnt = dly(m_kind, rd, cfg_slow_exit); m_wake = 1; end
            end
            default: begin
                m_idle = 0;
                if (m_cnt == 1) m_st = 0;
                m_cnt--;
            end
        endcase
    endtask

    task automatic check(input string tag, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        logic [5:0] a, e;
        a = {cke, busy, cmd_self_refresh, cmd_power_down, cmd_deep_pd, cmd_wake};
        e = {m_st != 1, m_st == 2, m_sre, m_pde, m_dpde, m_wake};
        check(cur_tag, int'(a), int'(e), "outputs {cke,busy,sre,pde,dpde,wake}");
    endtask

    // Drive inputs, take one edge, then compare at the falling edge.
    task automatic step(input bit xa, input bit nr, input bit rd);
        xfer_active = xa; new_req = nr; req_is_read = rd;
        @(posedge clk);
        model_edge(xa, nr, rd);
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic make_active();
        if (!cke) step(0, 1, 0);
        while (busy) step(1, 0, 0);
        step(1, 0, 0);
    endtask

    task automatic measure_entry(input logic [1:0] mode, input logic [1:0] to,
                                 input int exp, input string tag);
        int n = 0;
        make_active();
        cfg_mode = mode; cfg_timeout = to;
        step(1, 0, 0);
        while (cke && n < 400) begin step(0, 0, 0); n++; end
        check(tag, n, exp, "idle edges until entry");
    endtask

    task automatic measure_wake(input logic [1:0] mode, input bit rd, input bit slow,
                                input int exp, input string tag);
        int n = 0;
        cur_tag = tag;
        measure_entry(mode, 2'd0, 1, tag);
        cfg_slow_exit = slow;
        step(0, 1, rd);
        check(tag, int'(cmd_wake && cke), 1, "wake strobe with cke high");
        while (busy && n < 1000) begin n++; step(0, 0, 0); end
        check(tag, n, exp, "busy cycles after wake");
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R10: reset state
        check("R10", int'({cke, busy, cmd_self_refresh, cmd_power_down, cmd_deep_pd, cmd_wake}),
              6'b100000, "reset outputs");
        rst = 1'b0;

        // R1: mode off never enters
        cur_tag = "R1";
        cfg_mode = 2'd0; cfg_timeout = 2'd0;
        for (int i = 0; i < 300; i++) step(0, 0, 0);
        check("R1", int'(cke), 1, "cke after 300 idle cycles in mode 0");

        // R3: each timeout code, R2: strobes checked by the model
        cur_tag = "R3";
        measure_entry(2'd1, 2'd0, 1, "R3");
        measure_entry(2'd2, 2'd1, SHORT_T + 1, "R3");
        measure_entry(2'd3, 2'd2, LONG_T + 1, "R3");
        measure_entry(2'd1, 2'd3, 1, "R3");
        cur_tag = "R2";
        measure_entry(2'd3, 2'd0, 1, "R2");
        check("R2", int'(cmd_deep_pd), 1, "deep power-down strobe at entry");
        step(0, 0, 0);
        check("R2", int'(cmd_deep_pd), 0, "deep power-down strobe lasts one cycle");

        // R4: a request mid-countdown restarts it
        cur_tag = "R4";
        make_active();
        cfg_mode = 2'd2; cfg_timeout = 2'd1;
        step(1, 0, 0);
        for (int i = 0; i < 40; i++) step(0, 0, 0);
        step(0, 1, 0);
        check("R4", int'(cke), 1, "cke after request in countdown");
        begin
            int n = 0;
            while (cke && n < 400) begin step(0, 0, 0); n++; end
            check("R4", n, SHORT_T + 1, "idle edges after restart");
        end

        // R5 R6 R7 R8: exit waits
        measure_wake(2'd1, 1, 0, D_SR_RD, "R6");
        measure_wake(2'd1, 0, 1, D_SR_CMD, "R6");
        measure_wake(2'd2, 0, 1, D_PD_CMD, "R7");
        measure_wake(2'd2, 1, 0, D_PD_FAST, "R7");
        measure_wake(2'd2, 1, 1, D_PD_SLOW, "R7");
        measure_wake(2'd3, 1, 0, D_DEEP, "R8");
        measure_wake(2'd3, 0, 1, D_DEEP, "R5");

        // R9: reprogramming while parked does not change the stay
        cur_tag = "R9";
        measure_entry(2'd1, 2'd0, 1, "R9");
        cfg_mode = 2'd0; cfg_timeout = 2'd2;
        for (int i = 0; i < 20; i++) step(0, 0, 0);
        check("R9", int'(cke), 0, "cke stays low after mode set to 0");
        step(0, 1, 0);
        begin
            int n = 0;
            while (busy && n < 1000) begin n++; step(0, 0, 0); end
            check("R9", n, D_SR_CMD, "busy cycles use captured kind");
        end

        // R11: count restarts after the exit wait
        cur_tag = "R11";
        measure_entry(2'd2, 2'd0, 1, "R11");
        cfg_timeout = 2'd1;
        step(0, 1, 0);
        while (busy) step(0, 0, 0);
        begin
            int n = 0;
            while (cke && n < 400) begin step(0, 0, 0); n++; end
            check("R11", n, SHORT_T + 1, "idle edges after return to active");
        end

        // Random phases checked against the model
        cur_tag = "R5";
        for (int ph = 0; ph < 40; ph++) begin
            cfg_mode = 2'($urandom % 4);
            cfg_timeout = 2'($urandom % 4);
            for (int c = 0; c < 300; c++) begin
                bit xa, nr, rd;
                xa = ($urandom % 40) == 0;
                nr = ($urandom % 60) == 0;
                rd = $urandom % 2;
                cfg_slow_exit = $urandom % 2;
                step(xa, nr, rd);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule